// File: doc/BRIEF.md
# Programmable Chip Select with Bus Acknowledge Timing

This block is one programmable chip-select entry for a 32-bit master that runs asynchronous bus cycles. On every cycle it compares the upper address bits with a base address under a don't-care mask, and the 4-bit function code with a programmed code under its own don't-care mask. When both match and the entry is enabled, it drives an active-low chip select for the length of the cycle.

The entry can also end the cycle on the master's behalf. It drives the two active-low data-size acknowledge lines after a programmed number of wait states (zero to three). The pattern on those lines gives the port width: 8, 16 or 32 bits. A fast-termination option returns the acknowledge in the first clock of the cycle. One port-size code turns the internal acknowledge off and leaves termination to external devices. If an external acknowledge arrives before the internal one is due, the entry drops its own acknowledge for the rest of that cycle. Two registers program the entry through a write-only port.

All inputs are sampled on the rising clock edge. A "cycle" begins at the first edge that samples the address strobe low. It ends at the first edge that samples the strobe high.

Top module: `cs_dsack_entry`

## Requirements
- R1: After reset, cs_n is 1, dsack_n is 2'b11 and both registers hold zero. An unprogrammed entry never selects, even for address 0 and function code 0.
- R2: A write with wr_sel=0 loads the base register: [31:7] base address (compared against address bits 31..7), [6:3] function code, [2:1] wait-state count, [0] enable. A write with wr_sel=1 loads the option register: [31:7] address mask, [6:3] function-code mask, [2:1] port size, [0] fast termination.
- R3: An address bit takes part in the match only when its mask bit is 0. A set mask bit makes that bit a don't-care.
- R4: A function-code bit takes part in the match only when its mask bit is 0. This lets one entry serve several address-space types.
- R5: With the enable bit clear, the entry asserts neither cs_n nor dsack_n.
- R6: On a match, cs_n goes low after the first edge of the cycle. It goes high after the first edge that samples as_n high.
- R7: With fast termination off, dsack_n asserts after edge 2+W of the cycle, where W is the wait-state count (00 gives 0 waits, 01 gives 1, 10 gives 2, 11 gives 3).
- R8: Port size 01 gives dsack_n=2'b01 (16-bit). Port size 10 gives 2'b10 (8-bit). Port size 00 gives 2'b00 (32-bit, meant only for 32-bit DMA). Bit 1 is the wide-port line and bit 0 the narrow-port line.
- R9: Port size 11 never asserts dsack_n, whatever the wait-state count or fast-termination setting.
- R10: With fast termination on and port size not 11, dsack_n asserts after edge 1 of the cycle, together with cs_n. The wait-state count has no effect.
- R11: If ext_dsack_n is sampled other than 2'b11 at or before the edge where the internal acknowledge would assert, the internal acknowledge stays off for the rest of that cycle.
- R12: Once asserted, dsack_n holds its value until the cycle ends. It releases on the same edge as cs_n.
- R13: The wait count restarts in every cycle, so back-to-back cycles each show their full programmed latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 base, 1 option |
| wr_data | input | 32 | Register write data |
| bus_addr_hi | input | 25 | Bus address bits 31..7 |
| bus_fc | input | 4 | Bus function code |
| as_n | input | 1 | Address strobe, active low |
| ext_dsack_n | input | 2 | External acknowledge lines, active low |
| cs_n | output | 1 | Chip select, active low |
| dsack_n | output | 2 | Internal acknowledge lines, active low |

## Verification
The internal acknowledge and an external acknowledge can both become due on the same clock edge. The bench provokes this by driving the external lines low exactly on the edge where the programmed count expires, with one wait state and also with fast termination on edge 1. The expected outcome is that the internal lines never assert in that cycle while chip select still asserts. One clock later than that, the internal acknowledge must appear at its normal edge. Acknowledge release and chip-select release also share an edge, and the bench checks both on the edge after every cycle ends.

// File: rtl/cs_pkg.sv
package cs_pkg;

   typedef enum logic [1:0] {
      PSZ_32  = 2'b00,
      PSZ_16  = 2'b01,
      PSZ_8   = 2'b10,
      PSZ_EXT = 2'b11
   } port_size_e;

   localparam logic SEL_BASE = 1'b0;
   localparam logic SEL_OPT  = 1'b1;

   localparam int WAIT_W = 2;

   // Active-low acknowledge pattern: bit 1 wide line, bit 0 narrow line.
   function automatic logic [1:0] ack_pattern(input port_size_e sz);
      logic [1:0] pat;
      unique case (sz)
         PSZ_32:  pat = 2'b00;
         PSZ_16:  pat = 2'b01;
         PSZ_8:   pat = 2'b10;
         default: pat = 2'b11;
      endcase
      return pat;
   endfunction

endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
   import cs_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int FC_W  = 4,
   localparam int LO_W  = FC_W + WAIT_W + 1,
   localparam int CMP_W = REG_W - LO_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [REG_W-1:0]   wr_data,
   output logic [CMP_W-1:0]   base_addr,
   output logic [FC_W-1:0]    base_fc,
   output logic [WAIT_W-1:0]  wait_cnt,
   output logic               enable,
   output logic [CMP_W-1:0]   addr_mask,
   output logic [FC_W-1:0]    fc_mask,
   output port_size_e         port_size,
   output logic               fast_term
);

   if (CMP_W < 1) begin : g_bad_width
      $error("cs_cfg_regs: REG_W too small for the field layout");
   end

   logic [REG_W-1:0] base_q;
   logic [REG_W-1:0] opt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         opt_q  <= '0;
      end else if (wr_en) begin
         if (wr_sel == SEL_BASE) base_q <= wr_data;
         else                    opt_q  <= wr_data;
      end
   end

   always_comb begin
      base_addr = base_q[REG_W-1:LO_W];
      base_fc   = base_q[LO_W-1:WAIT_W+1];
      wait_cnt  = base_q[WAIT_W:1];
      enable    = base_q[0];
      addr_mask = opt_q[REG_W-1:LO_W];
      fc_mask   = opt_q[LO_W-1:WAIT_W+1];
      port_size = port_size_e'(opt_q[WAIT_W:1]);
      fast_term = opt_q[0];
   end

endmodule

// File: rtl/cs_decode.sv
module cs_decode #(
   parameter int CMP_W = 25,
   parameter int FC_W  = 4
) (
   input  logic [CMP_W-1:0] bus_addr_hi,
   input  logic [FC_W-1:0]  bus_fc,
   input  logic [CMP_W-1:0] base_addr,
   input  logic [CMP_W-1:0] addr_mask,
   input  logic [FC_W-1:0]  base_fc,
   input  logic [FC_W-1:0]  fc_mask,
   input  logic             enable,
   output logic             hit
);

   logic [CMP_W-1:0] addr_ok;
   logic [FC_W-1:0]  fc_ok;

   // One comparator per bit; a set mask bit turns the bit into don't-care.
   for (genvar i = 0; i < CMP_W; i++) begin : g_addr_bit
      assign addr_ok[i] = addr_mask[i] | ~(bus_addr_hi[i] ^ base_addr[i]);
   end

   for (genvar j = 0; j < FC_W; j++) begin : g_fc_bit
      assign fc_ok[j] = fc_mask[j] | ~(bus_fc[j] ^ base_fc[j]);
   end

   assign hit = enable & (&addr_ok) & (&fc_ok);

endmodule

// File: rtl/cs_ack_timer.sv
module cs_ack_timer
   import cs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_n,
   input  logic              hit,
   input  logic [1:0]        ext_dsack_n,
   input  logic [WAIT_W-1:0] wait_cnt,
   input  port_size_e        port_size,
   input  logic              fast_term,
   output logic              cs_n,
   output logic [1:0]        dsack_n
);

   localparam logic [WAIT_W-1:0] CNT_MAX = '1;

   logic              in_cyc_q;
   logic              sel_q;
   logic              ack_q;
   logic              term_q;
   logic [WAIT_W-1:0] cnt_q;
   logic [1:0]        pat_q;
   logic              ext_low;
   logic              int_ack_ok;

   assign ext_low    = (ext_dsack_n != 2'b11);
   assign int_ack_ok = (port_size != PSZ_EXT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cyc_q <= 1'b0;
         sel_q    <= 1'b0;
         ack_q    <= 1'b0;
         term_q   <= 1'b0;
         cnt_q    <= '0;
         pat_q    <= 2'b11;
      end else if (as_n) begin
         in_cyc_q <= 1'b0;
         sel_q    <= 1'b0;
         ack_q    <= 1'b0;
         term_q   <= 1'b0;
      end else if (!in_cyc_q) begin
         // first edge of a cycle: decide select, restart the wait count
         in_cyc_q <= 1'b1;
         sel_q    <= hit;
         cnt_q    <= '0;
         term_q   <= hit & ext_low;
         ack_q    <= hit & fast_term & int_ack_ok & ~ext_low;
         pat_q    <= ack_pattern(port_size);
      end else if (sel_q && !ack_q && !term_q) begin
         if (ext_low) begin
            term_q <= 1'b1;
         end else if (int_ack_ok && !fast_term && cnt_q == wait_cnt) begin
            ack_q <= 1'b1;
            pat_q <= ack_pattern(port_size);
         end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cs_n    = ~sel_q;
   assign dsack_n = ack_q ? pat_q : 2'b11;

   assert_cs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(as_n) |-> cs_n)
      else $error("cs_n low after strobe sampled high");

   assert_ack_needs_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (dsack_n != 2'b11) |-> !cs_n)
      else $error("acknowledge without chip select");

   assert_ack_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (dsack_n != 2'b11 && !as_n) |=> $stable(dsack_n))
      else $error("acknowledge changed inside a cycle");

   assert_ext_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!as_n && dsack_n == 2'b11 && ext_dsack_n != 2'b11) |=> dsack_n == 2'b11)
      else $error("internal acknowledge after external one");

   assert_no_ack_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dsack_n[0]) || $fell(dsack_n[1])) |-> $past(port_size) != PSZ_EXT)
      else $error("internal acknowledge with external port size");

   assert_cnt_bound_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (as_n && !$past(as_n)) |=> !in_cyc_q)
      else $error("cycle state not cleared at strobe release");

endmodule

// File: rtl/cs_dsack_entry.sv
module cs_dsack_entry
   import cs_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int FC_W   = 4,
   localparam int CMP_LSB = FC_W + WAIT_W + 1,
   localparam int CMP_W   = ADDR_W - CMP_LSB
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [ADDR_W-1:0]  wr_data,
   input  logic [CMP_W-1:0]   bus_addr_hi,
   input  logic [FC_W-1:0]    bus_fc,
   input  logic               as_n,
   input  logic [1:0]         ext_dsack_n,
   output logic               cs_n,
   output logic [1:0]         dsack_n
);

   if (ADDR_W <= CMP_LSB) begin : g_chk_addr
      $error("cs_dsack_entry: ADDR_W must exceed the low field width");
   end
   if (FC_W < 1) begin : g_chk_fc
      $error("cs_dsack_entry: FC_W must be at least 1");
   end

   logic [CMP_W-1:0]  base_addr;
   logic [CMP_W-1:0]  addr_mask;
   logic [FC_W-1:0]   base_fc;
   logic [FC_W-1:0]   fc_mask;
   logic [WAIT_W-1:0] wait_cnt;
   logic              enable;
   logic              fast_term;
   port_size_e        port_size;
   logic              hit;

   cs_cfg_regs #(.REG_W(ADDR_W), .FC_W(FC_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .base_addr (base_addr),
      .base_fc   (base_fc),
      .wait_cnt  (wait_cnt),
      .enable    (enable),
      .addr_mask (addr_mask),
      .fc_mask   (fc_mask),
      .port_size (port_size),
      .fast_term (fast_term)
   );

   cs_decode #(.CMP_W(CMP_W), .FC_W(FC_W)) u_dec (
      .bus_addr_hi (bus_addr_hi),
      .bus_fc      (bus_fc),
      .base_addr   (base_addr),
      .addr_mask   (addr_mask),
      .base_fc     (base_fc),
      .fc_mask     (fc_mask),
      .enable      (enable),
      .hit         (hit)
   );

   cs_ack_timer u_tmr (
      .clk         (clk),
      .rst_n       (rst_n),
      .as_n        (as_n),
      .hit         (hit),
      .ext_dsack_n (ext_dsack_n),
      .wait_cnt    (wait_cnt),
      .port_size   (port_size),
      .fast_term   (fast_term),
      .cs_n        (cs_n),
      .dsack_n     (dsack_n)
   );

   assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && $past(!enable) && $past(as_n)) |=> cs_n)
      else $error("select while disabled");

endmodule

// File: tb/cs_dsack_entry_bench.sv
module cs_dsack_entry_bench;

   localparam int CLK_P = 10;
   localparam logic [24:0] B = 25'h0012345;

   typedef struct packed {
      logic [24:0] b_hi;
      logic [3:0]  b_fc;
      logic [1:0]  b_dly;
      logic        b_v;
      logic [24:0] m_hi;
      logic [3:0]  m_fc;
      logic [1:0]  o_ps;
      logic        o_fte;
      logic [24:0] a_hi;
      logic [3:0]  a_fc;
      logic [3:0]  ext_at;
      logic        e_cs;
      logic [3:0]  e_lat;
      logic [1:0]  e_val;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{B, 4'h5, 2'd0, 1'b1, 25'h0, 4'h0, 2'b01, 1'b0, B,          4'h5, 4'd0, 1'b1, 4'd2, 2'b01},
      '{B, 4'h5, 2'd3, 1'b1, 25'h0, 4'h0, 2'b01, 1'b0, B,          4'h5, 4'd0, 1'b1, 4'd5, 2'b01},
      '{B, 4'h5, 2'd1, 1'b1, 25'h0, 4'h0, 2'b10, 1'b0, B,          4'h5, 4'd0, 1'b1, 4'd3, 2'b10},
      '{B, 4'h5, 2'd2, 1'b1, 25'h0, 4'h0, 2'b00, 1'b0, B,          4'h5, 4'd0, 1'b1, 4'd4, 2'b00},
      '{B, 4'h5, 2'd2, 1'b1, 25'h0, 4'h0, 2'b11, 1'b0, B,          4'h5, 4'd0, 1'b1, 4'd0, 2'b11},
      '{B, 4'h5, 2'd0, 1'b1, 25'h0, 4'h0, 2'b01, 1'b0, B,          4'h6, 4'd0, 1'b0, 4'd0, 2'b11},
      '{B, 4'h5, 2'd0, 1'b1, 25'h0, 4'h3, 2'b01, 1'b0, B,          4'h6, 4'd0, 1'b1, 4'd2, 2'b01},
      '{B, 4'h5, 2'd0, 1'b1, 25'h0, 4'h0, 2'b01, 1'b0, B ^ 25'h1,  4'h5, 4'd0, 1'b0, 4'd0, 2'b11},
      '{B, 4'h5, 2'd0, 1'b1, 25'h1, 4'h0, 2'b01, 1'b0, B ^ 25'h1,  4'h5, 4'd0, 1'b1, 4'd2, 2'b01},
      '{B, 4'h5, 2'd3, 1'b1, 25'h0, 4'h0, 2'b01, 1'b1, B,          4'h5, 4'd0, 1'b1, 4'd1, 2'b01},
      '{B, 4'h5, 2'd3, 1'b1, 25'h0, 4'h0, 2'b01, 1'b0, B,          4'h5, 4'd3, 1'b1, 4'd0, 2'b11},
      '{B, 4'h5, 2'd1, 1'b1, 25'h0, 4'h0, 2'b01, 1'b0, B,          4'h5, 4'd3, 1'b1, 4'd0, 2'b11},
      '{B, 4'h5, 2'd1, 1'b1, 25'h0, 4'h0, 2'b01, 1'b0, B,          4'h5, 4'd4, 1'b1, 4'd3, 2'b01},
      '{B, 4'h5, 2'd0, 1'b0, 25'h0, 4'h0, 2'b01, 1'b0, B,          4'h5, 4'd0, 1'b0, 4'd0, 2'b11},
      '{B, 4'h5, 2'd1, 1'b1, 25'h0, 4'h0, 2'b11, 1'b1, B,          4'h5, 4'd0, 1'b1, 4'd0, 2'b11},
      '{B, 4'h5, 2'd0, 1'b1, 25'h0, 4'h0, 2'b10, 1'b1, B,          4'h5, 4'd1, 1'b1, 4'd0, 2'b11}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic [24:0] bus_addr_hi = '0;
   logic [3:0]  bus_fc = '0;
   logic        as_n = 1'b1;
   logic [1:0]  ext_dsack_n = 2'b11;
   logic        cs_n;
   logic [1:0]  dsack_n;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P / 2) clk = ~clk;

   cs_dsack_entry u_cs_dsack_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_sel      (wr_sel),
      .wr_data     (wr_data),
      .bus_addr_hi (bus_addr_hi),
      .bus_fc      (bus_fc),
      .as_n        (as_n),
      .ext_dsack_n (ext_dsack_n),
      .cs_n        (cs_n),
      .dsack_n     (dsack_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic sel, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // One bus cycle of 8 edges; reports select at edge 1, first ack edge and value.
   task automatic bus_cycle(input logic [24:0] a, input logic [3:0] fc,
                            input int ext_at, output bit cs1,
                            output int lat, output logic [1:0] val,
                            output bit rel_ok);
      @(negedge clk);
      bus_addr_hi = a; bus_fc = fc; as_n = 1'b0;
      ext_dsack_n = (ext_at == 1) ? 2'b00 : 2'b11;
      cs1 = 1'b0; lat = 0; val = 2'b11;
      for (int e = 1; e <= 8; e++) begin
         @(posedge clk);
         @(negedge clk);
         if (e == 1) cs1 = !cs_n;
         if (dsack_n != 2'b11 && lat == 0) begin
            lat = e; val = dsack_n;
         end
         ext_dsack_n = (ext_at != 0 && e + 1 >= ext_at) ? 2'b00 : 2'b11;
      end
      as_n = 1'b1; ext_dsack_n = 2'b11;
      @(posedge clk);
      @(negedge clk);
      rel_ok = cs_n && dsack_n == 2'b11;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit cs1, rel;
      int lat;
      logic [1:0] val;

      repeat (3) @(negedge clk);
      // R1: reset state while held in reset
      check(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
      check(dsack_n == 2'b11, "R1 dsack_n in reset", dsack_n, 3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1/R5: zeroed registers match address 0 code 0 but enable is clear
      bus_cycle(25'h0, 4'h0, 0, cs1, lat, val, rel);
      check(!cs1, "R1 no select after reset", cs1, 0);
      check(lat == 0, "R1 no ack after reset", lat, 0);

      // R2..R13: table of programmed cycles
      for (int i = 0; i < NV; i++) begin
         write_reg(1'b0, {VEC[i].b_hi, VEC[i].b_fc, VEC[i].b_dly, VEC[i].b_v});
         write_reg(1'b1, {VEC[i].m_hi, VEC[i].m_fc, VEC[i].o_ps, VEC[i].o_fte});
         bus_cycle(VEC[i].a_hi, VEC[i].a_fc, VEC[i].ext_at, cs1, lat, val, rel);
         // R2 R3 R4 R5 R6: select decision and timing
         check(cs1 == VEC[i].e_cs, $sformatf("R6 R3 R4 R5 select vec%0d", i),
               cs1, VEC[i].e_cs);
         // R7 R9 R10 R11 R13: acknowledge edge
         check(lat == VEC[i].e_lat, $sformatf("R7 R9 R10 R11 R13 ack edge vec%0d", i),
               lat, VEC[i].e_lat);
         // R8: width pattern
         if (VEC[i].e_lat != 0)
            check(val == VEC[i].e_val, $sformatf("R8 ack pattern vec%0d", i),
                  val, VEC[i].e_val);
         // R12: release together on the edge after strobe high
         check(rel, $sformatf("R12 release vec%0d", i), rel, 1);
      end

      // R13: back-to-back cycles with three waits keep full latency
      write_reg(1'b0, {B, 4'h5, 2'd3, 1'b1});
      write_reg(1'b1, {25'h0, 4'h0, 2'b01, 1'b0});
      for (int k = 0; k < 2; k++) begin
         bus_cycle(B, 4'h5, 0, cs1, lat, val, rel);
         check(lat == 5, "R13 restart latency", lat, 5);
      end

      // R1: reset clears programmed registers
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      bus_cycle(B, 4'h5, 0, cs1, lat, val, rel);
      check(!cs1, "R1 registers cleared by reset", cs1, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule